// File: doc/BRIEF.md
# Regulator Control Register Bank with Serial Slave Port

This block sits between a two-wire serial bus (I2C, 7-bit addressing) and the control inputs of a nine-rail regulator controller. A host sets a register pointer with one byte and then either writes one data byte to that register or reads it back after a repeated start. The pointer survives a STOP, so a later read that sends no pointer returns the register last addressed. The pointer never advances on its own.

The bank holds the voltage codes, the per-rail on/off bits and the per-rail active-discharge bits. It also holds a read-only status byte and a handshake bit that tells software whether the bank still holds its power-up defaults. Two strap inputs choose the power-up codes of the PAD and CORE rails. The straps are captured while the reset is held. When the power-good input drops, every register returns to its default, using the captured straps. The block drives SDA as an open-drain line: it pulls the line low when `sda_oe` is 1 and otherwise leaves it to the pull-up.

Top module: `rail_ctrl_regbank`

## Requirements
- R1: The block acknowledges only the address byte 0x10 (slave address 0x08, write) or 0x11 (read) by pulling SDA low during the ninth clock. Any other address, including the general-call address 0x00, gets no acknowledge, and the rest of that transaction is ignored.
- R2: A write transaction is START, 0x10, pointer byte, data byte, STOP. It updates only the register the pointer selects. Further data bytes in the same transaction overwrite that same register, because the pointer never advances.
- R3: A read transaction is START, 0x10, pointer byte, repeated START, 0x11, then one byte sent MSB first, and it ends with a master NACK and STOP.
- R4: The pointer is kept across a STOP. A transaction START, 0x11, byte, NACK, STOP returns the register addressed by the most recent pointer byte.
- R5: Bit 7 of register 0 is a handshake flag. Reset sets it to 1. Writing 0 clears it, and writing 1 leaves it at its current value. Bits 4:0 of register 0 are the PAD code and are written normally.
- R6: While the reset is held, the block samples the strap inputs. The PAD code resets to 9 with its strap low and to 25 with it high. The CORE code (register 1, bits 4:0) resets to 0 with its strap low and to 9 with it high. A change of the straps after reset has no effect until the next reset.
- R7: With power-good low, every writable register returns to its default in the next cycle, including the handshake flag (set to 1) and the captured-strap codes.
- R8: Register layout and defaults:
  - Register 2 is 0x21: bit 6 is the MOT enable, bit 5 the MOT discharge, bits 4:0 the MOT code.
  - Register 3 is 0x29: bits 7:5 are the ANA code, bits 4:0 the CAM code.
  - Registers 4 and 5 are 0x36: bits 5:3 hold the TCXO and PLL codes, bits 2:0 the RX and TX codes.
  - Register 6 is the on/off byte, 0xE8: bit 7 PAD, bit 6 CORE, bit 5 ANA, bit 4 CAM, bit 3 TCXO, bit 2 PLL, bit 1 TX, bit 0 RX.
  - Register 7 holds the discharge bits in the same order and is 0xFF.
  - Output bit k of `rail_en` and `rail_dis` is rail k in the order PAD, CORE, ANA, CAM, TCXO, PLL, TX, RX, MOT.
- R9: The effective TCXO enable is register 6 bit 3 OR the `ext_en_tcxo` pin. The effective MOT enable is register 2 bit 6 OR the `ext_en_mot` pin.
- R10: Register 8 is read-only status. Bit 0 is the `ext_en_tcxo` pin, bit 1 reads 1 when no over-temperature is reported and 0 when one is, bit 2 is the `ext_en_mot` pin, and the other bits are 0. Writes to register 8 are acknowledged and change nothing.
- R11: Writes to pointers above 8 are acknowledged and change no register. Reads from them return 0x00.
- R12: SDA is released (`sda_oe` = 0) in the cycle after any STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-up reset; samples the straps |
| pgood | input | 1 | Power-good; low returns all registers to defaults |
| strap_pad_hi | input | 1 | Strap selecting the PAD reset code |
| strap_core_hi | input | 1 | Strap selecting the CORE reset code |
| ext_en_tcxo | input | 1 | External enable for the TCXO rail |
| ext_en_mot | input | 1 | External enable for the MOT rail |
| over_temp | input | 1 | Over-temperature indication, high on fault |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rail_en | output | 9 | Effective per-rail enables |
| rail_dis | output | 9 | Per-rail active-discharge enables |
| pad_code | output | 5 | PAD voltage code |
| core_code | output | 5 | CORE voltage code |
| mot_code | output | 5 | MOT voltage code |
| cam_code | output | 5 | CAM voltage code |
| ana_code | output | 3 | ANA voltage code |
| tcxo_code | output | 3 | TCXO voltage code |
| rx_code | output | 3 | RX voltage code |
| tx_code | output | 3 | TX voltage code |
| pll_code | output | 3 | PLL voltage code |

## Verification
The hardest state to reach from the ports is a strap level that differs from the value captured at reset at the moment power-good falls. The defaults must then come from the captured value, not from the live pins. The stimulus resets with both straps low, runs a full set of transactions, then raises both straps and pulses power-good low. It then reads the codes back, and only afterwards applies a real reset with the straps high to show that the new strap levels take effect. A second hard case is the pointer-less read: it is reached by ending a write transaction right after its pointer byte, or after a full write, and then issuing a bare read address.

// File: rtl/regbank_pkg.sv
// Package: shared constants, state type and default/mask functions for the
// regulator control register bank. Assumes nine rails and nine byte registers.
package regbank_pkg;

    localparam int NUM_RAILS   = 9;
    localparam int NUM_WREGS   = 8;
    localparam int STATUS_ADDR = 8;
    localparam int IDX_W       = $clog2(NUM_WREGS);

    localparam int REG_PADC = 0;
    localparam int REG_CORE = 1;
    localparam int REG_MOT  = 2;
    localparam int REG_ACAM = 3;
    localparam int REG_TCRX = 4;
    localparam int REG_PLTX = 5;
    localparam int REG_ONOF = 6;
    localparam int REG_DSCH = 7;

    localparam int RAIL_PAD  = 0;
    localparam int RAIL_TCXO = 4;
    localparam int RAIL_MOT  = 8;

    typedef enum logic [2:0] {
        SL_IDLE,
        SL_RX,
        SL_ACK,
        SL_TX,
        SL_RACK
    } slv_state_e;

    // Default content of a writable register; straps pick two of the codes.
    function automatic logic [7:0] reg_default(int idx, logic pad_hi, logic core_hi);
        case (idx)
            REG_PADC: reg_default = {1'b1, 2'b00, (pad_hi ? 5'd25 : 5'd9)};
            REG_CORE: reg_default = {3'b000, (core_hi ? 5'd9 : 5'd0)};
            REG_MOT:  reg_default = 8'h21;
            REG_ACAM: reg_default = 8'h29;
            REG_TCRX: reg_default = 8'h36;
            REG_PLTX: reg_default = 8'h36;
            REG_ONOF: reg_default = 8'hE8;
            default:  reg_default = 8'hFF;
        endcase
    endfunction

    // Bits a host write may change directly (the handshake flag is handled apart).
    function automatic logic [7:0] reg_wmask(int idx);
        case (idx)
            REG_PADC: reg_wmask = 8'h1F;
            REG_CORE: reg_wmask = 8'h1F;
            REG_MOT:  reg_wmask = 8'h7F;
            REG_TCRX: reg_wmask = 8'h3F;
            REG_PLTX: reg_wmask = 8'h3F;
            default:  reg_wmask = 8'hFF;
        endcase
    endfunction

    // New register value after a host write of d to register idx holding q.
    function automatic logic [7:0] reg_merge(int idx, logic [7:0] q, logic [7:0] d);
        logic [7:0] m;
        logic [7:0] r;
        m = reg_wmask(idx);
        r = (q & ~m) | (d & m);
        if (idx == REG_PADC) r[7] = q[7] & d[7];
        reg_merge = r;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
// Module: brings SCL/SDA into the clock domain through STAGES flip-flops and
// flags clock edges plus START/STOP conditions. Assumes the bus idles high
// and that each bus phase lasts several system clocks.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;

    // Shift both lines through the synchroniser chain and keep a delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_p  <= scl_s;
            sda_p  <= sda_s;
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_byte_slave.sv
// Module: byte-level serial slave. The first byte after the address sets the
// pointer; later bytes write the pointed register. A read sends the pointed
// register MSB first. The pointer persists across transactions and never
// advances. Assumes edge/condition flags from i2c_line_sync.
module i2c_byte_slave
    import regbank_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h08
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic [7:0] ptr,
    output logic       wr_en,
    output logic [7:0] wr_data
);
    slv_state_e state;
    logic [7:0] shreg;
    logic [7:0] txsh;
    logic [3:0] bitcnt;
    logic       is_addr;
    logic       reading;
    logic       ptr_done;

    // Bus protocol engine: receive, acknowledge, transmit and pointer upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SL_IDLE;
            shreg    <= '0;
            txsh     <= '0;
            bitcnt   <= '0;
            is_addr  <= 1'b0;
            reading  <= 1'b0;
            ptr_done <= 1'b0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state   <= SL_RX;
                is_addr <= 1'b1;
                reading <= 1'b0;
                bitcnt  <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= SL_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    SL_RX: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (is_addr) begin
                                if (shreg[7:1] == SLAVE_ADDR) begin
                                    sda_oe  <= 1'b1;
                                    reading <= shreg[0];
                                    state   <= SL_ACK;
                                end else begin
                                    state <= SL_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                state  <= SL_ACK;
                                if (!ptr_done) begin
                                    ptr      <= shreg;
                                    ptr_done <= 1'b1;
                                end else begin
                                    wr_en   <= 1'b1;
                                    wr_data <= shreg;
                                end
                            end
                        end
                    end
                    SL_ACK: begin
                        if (scl_fall) begin
                            if (reading) begin
                                state  <= SL_TX;
                                sda_oe <= ~rd_data[7];
                                txsh   <= {rd_data[6:0], 1'b0};
                                bitcnt <= 4'd1;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= SL_RX;
                                bitcnt <= '0;
                                if (is_addr) ptr_done <= 1'b0;
                            end
                            is_addr <= 1'b0;
                        end
                    end
                    SL_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= SL_RACK;
                            end else begin
                                sda_oe <= ~txsh[7];
                                txsh   <= {txsh[6:0], 1'b0};
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    SL_RACK: begin
                        if (scl_rise) state <= sda_s ? SL_IDLE : SL_ACK;
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r12_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    a_r1_drive_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    a_r2_write_after_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(ptr_done) && $past(scl_fall));

endmodule

// File: rtl/rail_reg_store.sv
// Module: byte registers with strap capture, the write-to-clear handshake
// flag, read-only status and the per-rail decode. Assumes wr_en is a
// single-cycle pulse and that the external pins are already synchronous.
module rail_reg_store
    import regbank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pgood,
    input  logic                 strap_pad_hi,
    input  logic                 strap_core_hi,
    input  logic                 ext_en_tcxo,
    input  logic                 ext_en_mot,
    input  logic                 over_temp,
    input  logic                 wr_en,
    input  logic [7:0]           wr_addr,
    input  logic [7:0]           wr_data,
    input  logic [7:0]           rd_addr,
    output logic [7:0]           rd_data,
    output logic [NUM_RAILS-1:0] rail_en,
    output logic [NUM_RAILS-1:0] rail_dis,
    output logic [4:0]           pad_code,
    output logic [4:0]           core_code,
    output logic [4:0]           mot_code,
    output logic [4:0]           cam_code,
    output logic [2:0]           ana_code,
    output logic [2:0]           tcxo_code,
    output logic [2:0]           rx_code,
    output logic [2:0]           tx_code,
    output logic [2:0]           pll_code
);
    logic [NUM_WREGS-1:0][7:0] regs_q;
    logic                      cap_pad;
    logic                      cap_core;
    logic [7:0]                status_b;

    // Capture the straps while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_pad  <= strap_pad_hi;
            cap_core <= strap_core_hi;
        end
    end

    // Register file: reset/power-good defaults, then masked host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WREGS; i++)
                regs_q[i] <= reg_default(i, strap_pad_hi, strap_core_hi);
        end else if (!pgood) begin
            for (int i = 0; i < NUM_WREGS; i++)
                regs_q[i] <= reg_default(i, cap_pad, cap_core);
        end else if (wr_en) begin
            for (int i = 0; i < NUM_WREGS; i++)
                if (wr_addr == 8'(i)) regs_q[i] <= reg_merge(i, regs_q[i], wr_data);
        end
    end

    // Read path: writable bank, status byte, zero elsewhere.
    always_comb begin
        status_b = {5'b00000, ext_en_mot, ~over_temp, ext_en_tcxo};
        if (rd_addr < 8'(NUM_WREGS))      rd_data = regs_q[rd_addr[IDX_W-1:0]];
        else if (rd_addr == 8'(STATUS_ADDR)) rd_data = status_b;
        else                              rd_data = 8'h00;
    end

    // Per-rail enable and discharge decode from the on/off and discharge bytes.
    for (genvar k = 0; k < NUM_RAILS - 1; k++) begin : g_rail
        if (k == RAIL_TCXO) begin : g_ext
            assign rail_en[k] = regs_q[REG_ONOF][7-k] | ext_en_tcxo;
        end else begin : g_reg
            assign rail_en[k] = regs_q[REG_ONOF][7-k];
        end
        assign rail_dis[k] = regs_q[REG_DSCH][7-k];
    end
    assign rail_en[RAIL_MOT]  = regs_q[REG_MOT][6] | ext_en_mot;
    assign rail_dis[RAIL_MOT] = regs_q[REG_MOT][5];

    assign pad_code  = regs_q[REG_PADC][4:0];
    assign core_code = regs_q[REG_CORE][4:0];
    assign mot_code  = regs_q[REG_MOT][4:0];
    assign cam_code  = regs_q[REG_ACAM][4:0];
    assign ana_code  = regs_q[REG_ACAM][7:5];
    assign tcxo_code = regs_q[REG_TCRX][5:3];
    assign rx_code   = regs_q[REG_TCRX][2:0];
    assign pll_code  = regs_q[REG_PLTX][5:3];
    assign tx_code   = regs_q[REG_PLTX][2:0];

    a_r10_r11_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= 8'(NUM_WREGS) && pgood) |=> $stable(regs_q));

    a_r5_flag_never_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(regs_q[REG_PADC][7]) |-> $past(!pgood));

endmodule

// File: rtl/rail_ctrl_regbank.sv
// Module: top of the regulator control register bank. It joins the line
// synchroniser, the byte slave and the register store. SDA is open-drain:
// sda_oe = 1 pulls the line low. Assumes one synchronous clock domain.
module rail_ctrl_regbank
    import regbank_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h08,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pgood,
    input  logic       strap_pad_hi,
    input  logic       strap_core_hi,
    input  logic       ext_en_tcxo,
    input  logic       ext_en_mot,
    input  logic       over_temp,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    output logic [8:0] rail_en,
    output logic [8:0] rail_dis,
    output logic [4:0] pad_code,
    output logic [4:0] core_code,
    output logic [4:0] mot_code,
    output logic [4:0] cam_code,
    output logic [2:0] ana_code,
    output logic [2:0] tcxo_code,
    output logic [2:0] rx_code,
    output logic [2:0] tx_code,
    output logic [2:0] pll_code
);
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic [7:0] ptr;
    logic [7:0] rd_data;
    logic       wr_en;
    logic [7:0] wr_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_byte_slave #(.SLAVE_ADDR(SLAVE_ADDR)) u_slave (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr), .wr_en(wr_en),
        .wr_data(wr_data)
    );

    rail_reg_store u_store (
        .clk(clk), .rst_n(rst_n), .pgood(pgood),
        .strap_pad_hi(strap_pad_hi), .strap_core_hi(strap_core_hi),
        .ext_en_tcxo(ext_en_tcxo), .ext_en_mot(ext_en_mot), .over_temp(over_temp),
        .wr_en(wr_en), .wr_addr(ptr), .wr_data(wr_data), .rd_addr(ptr),
        .rd_data(rd_data), .rail_en(rail_en), .rail_dis(rail_dis),
        .pad_code(pad_code), .core_code(core_code), .mot_code(mot_code),
        .cam_code(cam_code), .ana_code(ana_code), .tcxo_code(tcxo_code),
        .rx_code(rx_code), .tx_code(tx_code), .pll_code(pll_code)
    );

    a_r7_discharge_default: assert property (@(posedge clk) disable iff (!rst_n)
        !pgood |=> (rail_dis == 9'h1FF));

endmodule

// File: tb/sim_rail_ctrl_regbank.sv
module sim_rail_ctrl_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int WD_CYCLES  = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pgood = 1'b1;
    logic strap_pad_hi = 1'b0;
    logic strap_core_hi = 1'b0;
    logic ext_en_tcxo = 1'b0;
    logic ext_en_mot = 1'b0;
    logic over_temp = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [8:0] rail_en, rail_dis;
    logic [4:0] pad_code, core_code, mot_code, cam_code;
    logic [2:0] ana_code, tcxo_code, rx_code, tx_code, pll_code;
    logic sda_line;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    rail_ctrl_regbank u0 (
        .clk(clk), .rst_n(rst_n), .pgood(pgood), .strap_pad_hi(strap_pad_hi),
        .strap_core_hi(strap_core_hi), .ext_en_tcxo(ext_en_tcxo),
        .ext_en_mot(ext_en_mot), .over_temp(over_temp), .scl_in(scl_m),
        .sda_in(sda_line), .sda_oe(sda_oe), .rail_en(rail_en), .rail_dis(rail_dis),
        .pad_code(pad_code), .core_code(core_code), .mot_code(mot_code),
        .cam_code(cam_code), .ana_code(ana_code), .tcxo_code(tcxo_code),
        .rx_code(rx_code), .tx_code(tx_code), .pll_code(pll_code)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = nack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        bit k0, k1, k2;
        bus_start;
        send_byte(8'h10, k0);
        send_byte(a, k1);
        send_byte(d, k2);
        bus_stop;
        chk(k0 && k1 && k2, "R1 write acks", {k0, k1, k2}, 3'b111);
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        bit k0, k1, k2;
        bus_start;
        send_byte(8'h10, k0);
        send_byte(a, k1);
        bus_start;
        send_byte(8'h11, k2);
        recv_byte(1'b1, d);
        bus_stop;
        chk(k0 && k1 && k2, "R3 read acks", {k0, k1, k2}, 3'b111);
    endtask

    task automatic read_noptr(output logic [7:0] d);
        bit k0;
        bus_start;
        send_byte(8'h11, k0);
        recv_byte(1'b1, d);
        bus_stop;
        chk(k0, "R4 bare read ack", k0, 1);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk(rail_en == 9'h017, "R8 reset rail_en", rail_en, 9'h017);
        chk(rail_dis == 9'h1FF, "R8 reset rail_dis", rail_dis, 9'h1FF);
        chk(pad_code == 5'd9 && core_code == 5'd0, "R6 strap-low codes",
            {pad_code, core_code}, {5'd9, 5'd0});
        chk(sda_oe == 1'b0, "R12 idle release", sda_oe, 0);
        reg_read(8'h00, d); chk(d == 8'h89, "R5 flag set at reset", d, 8'h89);
        reg_read(8'h02, d); chk(d == 8'h21, "R8 reg2 default", d, 8'h21);
        reg_read(8'h06, d); chk(d == 8'hE8, "R8 reg6 default", d, 8'hE8);
        reg_read(8'h07, d); chk(d == 8'hFF, "R8 reg7 default", d, 8'hFF);
        chk(mot_code == 5'd1 && cam_code == 5'd9 && ana_code == 3'd1 && tcxo_code == 3'd6,
            "R8 code defaults", {mot_code, cam_code, ana_code, tcxo_code},
            {5'd1, 5'd9, 3'd1, 3'd6});
    endtask

    task automatic t_addressing;
        bit k;
        logic [7:0] d;
        bus_start; send_byte(8'h00, k); bus_stop;
        chk(!k, "R1 general call ignored", k, 0);
        bus_start; send_byte(8'h12, k); bus_stop;
        chk(!k, "R1 foreign address ignored", k, 0);
        bus_start; send_byte(8'h10, k); send_byte(8'h04, k); bus_stop;
        chk(sda_oe == 1'b0, "R12 release after stop", sda_oe, 0);
        read_noptr(d);
        chk(d == 8'h36, "R4 pointer-only transaction then bare read", d, 8'h36);
    endtask

    task automatic t_write;
        bit k0, k1, k2, k3;
        logic [7:0] d;
        reg_write(8'h03, 8'hA5);
        chk(cam_code == 5'd5 && ana_code == 3'd5, "R2 reg3 fields",
            {cam_code, ana_code}, {5'd5, 3'd5});
        reg_read(8'h04, d); chk(d == 8'h36, "R2 neighbour untouched", d, 8'h36);
        bus_start;
        send_byte(8'h10, k0); send_byte(8'h05, k1);
        send_byte(8'h11, k2); send_byte(8'h2A, k3);
        bus_stop;
        reg_read(8'h05, d); chk(d == 8'h2A, "R2 second byte same register", d, 8'h2A);
        chk(tx_code == 3'd2 && pll_code == 3'd5, "R2 reg5 fields",
            {tx_code, pll_code}, {3'd2, 3'd5});
        reg_read(8'h06, d); chk(d == 8'hE8, "R2 no auto-increment", d, 8'hE8);
        reg_read(8'h03, d); chk(d == 8'hA5, "R3 combined read", d, 8'hA5);
    endtask

    task automatic t_pointer;
        logic [7:0] d;
        reg_write(8'h01, 8'h1F);
        read_noptr(d); chk(d == 8'h1F, "R4 pointer kept after stop", d, 8'h1F);
        chk(core_code == 5'd31, "R4 core code written", core_code, 31);
    endtask

    task automatic t_flag;
        logic [7:0] d;
        reg_write(8'h00, 8'h8C);
        reg_read(8'h00, d); chk(d == 8'h8C, "R5 write 1 keeps flag", d, 8'h8C);
        chk(pad_code == 5'd12, "R5 pad code written", pad_code, 12);
        reg_write(8'h00, 8'h0D);
        reg_read(8'h00, d); chk(d == 8'h0D, "R5 write 0 clears flag", d, 8'h0D);
        reg_write(8'h00, 8'h8E);
        reg_read(8'h00, d); chk(d == 8'h0E, "R5 write 1 cannot set flag", d, 8'h0E);
    endtask

    task automatic t_or_enables;
        reg_write(8'h06, 8'hE0);
        chk(rail_en[4] == 1'b0, "R9 tcxo off", rail_en[4], 0);
        ext_en_tcxo = 1'b1; tick(2);
        chk(rail_en[4] == 1'b1, "R9 tcxo by pin", rail_en[4], 1);
        ext_en_mot = 1'b1; tick(2);
        chk(rail_en[8] == 1'b1, "R9 mot by pin", rail_en[8], 1);
        ext_en_mot = 1'b0; tick(2);
        chk(rail_en[8] == 1'b0, "R9 mot off", rail_en[8], 0);
        reg_write(8'h02, 8'h41);
        chk(rail_en[8] == 1'b1 && rail_dis[8] == 1'b0, "R9 mot by bit",
            {rail_en[8], rail_dis[8]}, 2'b10);
    endtask

    task automatic t_status;
        logic [7:0] d;
        reg_read(8'h08, d); chk(d == 8'h03, "R10 status tcxo pin, no fault", d, 8'h03);
        ext_en_mot = 1'b1; over_temp = 1'b1;
        reg_read(8'h08, d); chk(d == 8'h05, "R10 status mot pin, fault", d, 8'h05);
        reg_write(8'h08, 8'hFF);
        reg_read(8'h08, d); chk(d == 8'h05, "R10 status write ignored", d, 8'h05);
        ext_en_mot = 1'b0; over_temp = 1'b0; ext_en_tcxo = 1'b0;
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        reg_write(8'h0C, 8'h55);
        reg_read(8'h0C, d); chk(d == 8'h00, "R11 unmapped reads zero", d, 0);
        reg_read(8'h07, d); chk(d == 8'hFF, "R11 reg7 unchanged", d, 8'hFF);
        reg_write(8'h07, 8'h0F);
        chk(rail_dis == 9'h0F0, "R8 discharge order", rail_dis, 9'h0F0);
    endtask

    task automatic t_pgood;
        logic [7:0] d;
        strap_pad_hi = 1'b1; strap_core_hi = 1'b1;
        pgood = 1'b0; tick(3);
        pgood = 1'b1; tick(2);
        chk(rail_dis == 9'h1FF && rail_en == 9'h017, "R7 defaults after power-good drop",
            {rail_dis, rail_en}, {9'h1FF, 9'h017});
        chk(pad_code == 5'd9 && core_code == 5'd0, "R6 captured straps reused",
            {pad_code, core_code}, {5'd9, 5'd0});
        reg_read(8'h00, d); chk(d == 8'h89, "R7 flag back to 1", d, 8'h89);
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(2);
        chk(pad_code == 5'd25 && core_code == 5'd9, "R6 strap-high codes",
            {pad_code, core_code}, {5'd25, 5'd9});
        reg_read(8'h00, d); chk(d == 8'h99, "R6 reg0 strap-high", d, 8'h99);
        chk(sda_oe == 1'b0, "R12 release at end", sda_oe, 0);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset;
        t_addressing;
        t_write;
        t_pointer;
        t_flag;
        t_or_enables;
        t_status;
        t_unmapped;
        t_pgood;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual hung, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule